// File: doc/BRIEF.md
# Parallel Register Write Port

This block is the write side of a microprocessor-style parallel bus that loads the tuning registers of a numerically controlled oscillator. A host places a 16-bit word and a 3-bit address on the bus and pulses an active-low write strobe. The word and address are held on the strobe's rising edge. This strobe is asynchronous to the master clock.

The captured word is not written straight into its destination. A toggle flag carries the write event into the master clock domain through two synchronizer flops. An edge on the synchronized flag produces a single-cycle commit pulse. On that pulse the word goes into the addressed destination register. The commit therefore always lands on a defined clock edge, even when the strobe edge falls close to a clock edge.

The destinations are two 32-bit frequency words and four 12-bit phase words. Each frequency word is written as two 16-bit halves. A low-half write only parks the data in a shadow register. The high-half write then updates the full 32-bit word in one cycle, so the oscillator never sees a half-updated frequency.

Top module: `pbus_write_port`

## Requirements
- R1: While the active-low reset `rst_n` is low, every frequency and phase output reads zero. The shadow low halves are cleared as well, so a high-half write made after reset yields `{data, 16'h0000}`.
- R2: A write to address 0 (frequency 0) or address 2 (frequency 1) stores the word as the low half in a shadow register and leaves both frequency outputs unchanged.
- R3: A write to address 1 or address 3 sets frequency output 0 or 1 to `{data, shadow low half}` in a single clock cycle.
- R4: A write to address 4, 5, 6 or 7 loads `data[11:0]` into phase output 0, 1, 2 or 3. Data bits 15:12 are ignored.
- R5: When the strobe rises in the middle of a clock period, the new value is not visible after the second master clock rising edge that follows. It is visible after the third.
- R6: When the strobe rises on the same instant as a clock rising edge, the new value is visible after the second or the third following rising edge, and after the third at the latest.
- R7: Each write changes at most one destination output, and only in the cycle after a commit. Every other output keeps its value.
- R8: Changes to the address or data bus after the strobe has risen have no effect on the committed value.
- R9: Each strobe rising edge gives exactly one commit pulse, lasting one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_n | input | 1 | Active-low write strobe; its rising edge captures the bus |
| addr | input | 3 | Destination address |
| data | input | 16 | Write data word |
| freq_o | output | 2x32 | Frequency words, index 0 and 1 |
| phase_o | output | 4x12 | Phase words, index 0 to 3 |

## Verification
Two events can fall in the same cycle: the asynchronous strobe edge, which flips the capture flag, and the clock edge that samples the synchronizer. The bench provokes this overlap by raising the strobe exactly on a clock rising edge. For that case it accepts the update after either the second or the third following edge, and requires it by the third. The bench also sweeps every address with several data patterns, using strobes placed mid-period. For these it checks that the old value is still present one edge before the update and that the new value is present on the expected edge.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int N_FREQ  = 2;
    localparam int N_PHASE = 4;
    localparam int PHASE_W = 12;
endpackage

// File: rtl/pbus_capture.sv
// Strobe-domain holding stage: the bus and a toggle flag are registered on the strobe's rising edge.
module pbus_capture #(
    parameter int DW = pbus_pkg::DATA_W,
    parameter int AW = pbus_pkg::ADDR_W
) (
    input  logic          wr_n,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          tog_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          tog;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d      = hold_q;
        hold_d.addr = addr_i;
        hold_d.data = data_i;
        hold_d.tog  = ~hold_q.tog;
    end

    always_ff @(posedge wr_n or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign addr_o = hold_q.addr;
    assign data_o = hold_q.data;
    assign tog_o  = hold_q.tog;
endmodule

// File: rtl/pbus_sync.sv
// Two-flop synchronizer for the toggle flag; a third flop gives the commit pulse by edge detection.
module pbus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic commit_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = tog_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign commit_o = sync_q.s2 ^ sync_q.s3;
endmodule

// File: rtl/pbus_regfile.sv
// Destination registers with low-half shadows; written only on the commit pulse.
module pbus_regfile #(
    parameter int DW = pbus_pkg::DATA_W,
    parameter int AW = pbus_pkg::ADDR_W,
    parameter int NF = pbus_pkg::N_FREQ,
    parameter int NP = pbus_pkg::N_PHASE,
    parameter int PW = pbus_pkg::PHASE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_i,
    input  logic [AW-1:0]              addr_i,
    input  logic [DW-1:0]              data_i,
    output logic [NF-1:0][2*DW-1:0]    freq_o,
    output logic [NP-1:0][PW-1:0]      phase_o
);
    localparam int FIW = (NF > 1) ? $clog2(NF) : 1;
    localparam int PIW = (NP > 1) ? $clog2(NP) : 1;

    typedef struct packed {
        logic [NF-1:0][DW-1:0]   shadow;
        logic [NF-1:0][2*DW-1:0] freq;
        logic [NP-1:0][PW-1:0]   phase;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [FIW-1:0] fidx;
    logic [AW-1:0]  poff;
    logic [PIW-1:0] pidx;
    logic           is_freq;

    always_comb begin
        fidx    = addr_i[FIW:1];
        poff    = addr_i - AW'(2 * NF);
        pidx    = poff[PIW-1:0];
        is_freq = (int'(addr_i) < 2 * NF);
        regs_d  = regs_q;
        if (commit_i) begin
            if (is_freq) begin
                if (addr_i[0]) regs_d.freq[fidx]   = {data_i, regs_q.shadow[fidx]};
                else           regs_d.shadow[fidx] = data_i;
            end else begin
                regs_d.phase[pidx] = data_i[PW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign freq_o  = regs_q.freq;
    assign phase_o = regs_q.phase;
endmodule

// File: rtl/pbus_write_port.sv
module pbus_write_port #(
    parameter int DW = pbus_pkg::DATA_W,
    parameter int AW = pbus_pkg::ADDR_W,
    parameter int NF = pbus_pkg::N_FREQ,
    parameter int NP = pbus_pkg::N_PHASE,
    parameter int PW = pbus_pkg::PHASE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_n,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           data,
    output logic [NF-1:0][2*DW-1:0] freq_o,
    output logic [NP-1:0][PW-1:0]   phase_o
);
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic          hold_tog;
    logic          commit;

    pbus_capture #(.DW(DW), .AW(AW)) u_cap (
        .wr_n   (wr_n),
        .rst_n  (rst_n),
        .addr_i (addr),
        .data_i (data),
        .addr_o (hold_addr),
        .data_o (hold_data),
        .tog_o  (hold_tog)
    );

    pbus_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tog_i    (hold_tog),
        .commit_o (commit)
    );

    pbus_regfile #(.DW(DW), .AW(AW), .NF(NF), .NP(NP), .PW(PW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .addr_i   (hold_addr),
        .data_i   (hold_data),
        .freq_o   (freq_o),
        .phase_o  (phase_o)
    );
endmodule

// File: rtl/pbus_write_port_chk.sv
module pbus_write_port_chk #(
    parameter int DW = pbus_pkg::DATA_W,
    parameter int AW = pbus_pkg::ADDR_W,
    parameter int NF = pbus_pkg::N_FREQ,
    parameter int NP = pbus_pkg::N_PHASE,
    parameter int PW = pbus_pkg::PHASE_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    commit,
    input logic [AW-1:0]           hold_addr,
    input logic [DW-1:0]           hold_data,
    input logic [NF-1:0][2*DW-1:0] freq_o,
    input logic [NP-1:0][PW-1:0]   phase_o
);
    localparam int PIW = (NP > 1) ? $clog2(NP) : 1;

    logic [NF-1:0][2*DW-1:0] prev_f;
    logic [NP-1:0][PW-1:0]   prev_p;
    logic [NF+NP-1:0]        chg;
    logic [AW-1:0]           poff;
    logic [PIW-1:0]          pidx;

    always_ff @(posedge clk) begin
        prev_f <= freq_o;
        prev_p <= phase_o;
    end

    always_comb begin
        for (int i = 0; i < NF; i++) chg[i]      = (freq_o[i] != prev_f[i]);
        for (int j = 0; j < NP; j++) chg[NF + j] = (phase_o[j] != prev_p[j]);
        poff = hold_addr - AW'(2 * NF);
        pidx = poff[PIW-1:0];
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (freq_o == '0 && phase_o == '0);
        end
    end

    // R7
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (freq_o == $past(freq_o) && phase_o == $past(phase_o)));

    // R4
    phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && int'(hold_addr) >= 2 * NF) |=> phase_o[$past(pidx)] == $past(hold_data[PW-1:0]));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

bind pbus_write_port pbus_write_port_chk #(.DW(DW), .AW(AW), .NF(NF), .NP(NP), .PW(PW)) u_chk (.*);

// File: tb/tb_pbus_write_port.sv
`timescale 1ns/1ps
module tb_pbus_write_port;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_n = 1'b1;
    logic [2:0]        addr = '0;
    logic [15:0]       data = '0;
    logic [1:0][31:0]  freq_o;
    logic [3:0][11:0]  phase_o;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] exp_f  [2];
    logic [15:0] exp_sh [2];
    logic [11:0] exp_p  [4];

    always #4 clk = ~clk;

    pbus_write_port dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data),
        .freq_o(freq_o), .phase_o(phase_o)
    );

    task automatic clear_model();
        for (int i = 0; i < 2; i++) begin exp_f[i] = '0; exp_sh[i] = '0; end
        for (int j = 0; j < 4; j++) exp_p[j] = '0;
    endtask

    task automatic apply(input logic [2:0] a, input logic [15:0] d);
        if (a < 3'd4) begin
            if (a[0]) exp_f[a[1]] = {d, exp_sh[a[1]]};
            else      exp_sh[a[1]] = d;
        end else begin
            exp_p[a - 3'd4] = d[11:0];
        end
    endtask

    task automatic cmp_all(input string tag);
        for (int i = 0; i < 2; i++) begin
            vectors++;
            if (freq_o[i] !== exp_f[i]) begin
                errors++;
                $display("FAIL %s freq%0d actual=%h expected=%h", tag, i, freq_o[i], exp_f[i]);
            end
        end
        for (int j = 0; j < 4; j++) begin
            vectors++;
            if (phase_o[j] !== exp_p[j]) begin
                errors++;
                $display("FAIL %s phase%0d actual=%h expected=%h", tag, j, phase_o[j], exp_p[j]);
            end
        end
    endtask

    // Strobe is lowered at a falling clock edge and raised either 2 ns later or on the next rising edge.
    // After the strobe rises, the bus is scrambled (R8).
    task automatic strobe(input logic [2:0] a, input logic [15:0] d, input bit coincide);
        @(negedge clk);
        addr = a; data = d; wr_n = 1'b0;
        if (coincide) begin @(posedge clk); wr_n = 1'b1; end
        else begin #2; wr_n = 1'b1; end
        #1;
        addr = ~a; data = ~d;
    endtask

    // R5: mid-period strobe, old after 2nd edge, new after 3rd edge
    task automatic write_mid(input logic [2:0] a, input logic [15:0] d, input string tag);
        strobe(a, d, 1'b0);
        @(posedge clk); @(posedge clk); #1;
        cmp_all({tag, " R5 before"});
        @(posedge clk); #1;
        apply(a, d);
        cmp_all({tag, " R5 after"});
    endtask

    // R6: strobe on a rising edge, old after 1st edge, new by 3rd edge
    task automatic write_coin(input logic [2:0] a, input logic [15:0] d);
        strobe(a, d, 1'b1);
        @(posedge clk); #1;
        cmp_all("R6 before");
        @(posedge clk); @(posedge clk); #1;
        apply(a, d);
        cmp_all("R6 after");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        #1;
        cmp_all("R1 reset");
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // Sweep: every address, several patterns; covers R2 R3 R4 R7 R8 R9
        for (int k = 0; k < 6; k++) begin
            for (int a = 0; a < 8; a++) begin
                logic [15:0] d;
                d = 16'(((k + 1) * 16'h3B29) ^ (a * 16'h1111) ^ (k == 5 ? 16'hFFFF : 16'h0));
                write_mid(3'(a), d, (a < 4) ? ((a % 2 == 0) ? "R2 low" : "R3 high") : "R4 phase");
            end
        end

        // R2: low halves alone must not move the frequency outputs
        write_mid(3'd0, 16'hDEAD, "R2 lone low f0");
        write_mid(3'd2, 16'hBEEF, "R2 lone low f1");
        // R3: high half picks up the parked low half
        write_mid(3'd3, 16'h0F0F, "R3 f1 combine");
        write_mid(3'd1, 16'hF0F0, "R3 f0 combine");
        // R4: upper data bits ignored
        write_mid(3'd6, 16'hF123, "R4 upper ignored");

        // R6: strobe coincident with a clock edge
        for (int a = 0; a < 8; a++) write_coin(3'(a), 16'(16'h5A00 + a * 16'h0101));

        // R9: back-to-back writes to the same register each land once
        write_mid(3'd5, 16'h0AAA, "R9 first");
        write_mid(3'd5, 16'h0555, "R9 second");

        // R1: reset mid-run clears outputs and shadows
        @(negedge clk); rst_n = 1'b0;
        clear_model();
        @(posedge clk); #1;
        cmp_all("R1 mid reset");
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        write_mid(3'd1, 16'h7777, "R1 shadow cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule